// File: doc/BRIEF.md
# Emulation and External Chip-Select Decoder

This block looks at every bus address put out by the processor when the device runs with its external bus enabled. It produces two active-low select strobes for board logic.

The emulation select marks cycles that would have reached on-chip program flash. A development board uses it to steer those cycles to substitute RAM. The external select marks every other cycle aimed at external address space. The register block never produces a select. This covers its implemented registers, its unimplemented holes and the port registers that leave the map when the bus is expanded. A no-access flag tells external devices that the current cycle is an internal free cycle, so they ignore any data left on the bus.

The selects follow the four-phase bus cycle. They open in phases S1 to S3 and close in S0, which stands for the short high pulse after each falling edge of the external clock. They stay open through S0 when the cycle is stretched and the external clock runs freely. All outputs are registered, so each one reflects the inputs sampled one clock edge earlier.

Top module: `chip_select_decoder`

## Requirements
- R1: While reset is held and on the first edge after it, both selects read 1 and no_access reads 0.
- R2: When cs_enable is 0 or expanded is 0, both selects read 1 one cycle later, whatever the address.
- R3: With flash_enable = 1, an address in 0x8000–0xFFFF (paged and upper fixed windows) drives emu_cs_n to 0 and ext_cs_n to 1 one cycle later, in phases S1–S3 (bus_phase 1, 2, 3).
- R4: The window 0x4000–0x7FFF is flash space only when fixed_flash_hi = 1. With fixed_flash_hi = 0 it is external space.
- R5: With flash_enable = 0, the flash windows become external space and drive ext_cs_n to 0.
- R6: The 1 KiB register block at address {1'b0, reg_base, 10'b0} asserts neither select for any offset. This includes holes and removed port registers, and the block takes priority over the flash windows.
- R7: emu_cs_n and ext_cs_n are never 0 in the same cycle.
- R8: In phase S0 (bus_phase = 0), both selects read 1 one cycle later, unless stretched = 1 and eclk_free_run = 1. In that case they follow the address decode.
- R9: no_access equals free_cycle delayed by one clock.
- R10: Addresses outside the register block and the flash windows, including 0x0000–0x3FFF, drive ext_cs_n to 0 when selects are enabled and the phase is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Current bus address |
| expanded | input | 1 | Device is in an expanded-bus mode |
| cs_enable | input | 1 | Select pins enabled (otherwise general-purpose I/O) |
| flash_enable | input | 1 | On-chip flash present in the memory map |
| fixed_flash_hi | input | 1 | Maps flash into 0x4000–0x7FFF |
| reg_base | input | 5 | Register block base, address bits 14:10 |
| bus_phase | input | 2 | Bus cycle phase S0..S3 |
| stretched | input | 1 | Current access is stretched |
| eclk_free_run | input | 1 | External clock runs freely |
| free_cycle | input | 1 | Internal free cycle |
| emu_cs_n | output | 1 | Emulation select, active low |
| ext_cs_n | output | 1 | External select, active low |
| no_access | output | 1 | No-access flag |

## Verification
Two functions can meet in one cycle: the register-block exclusion and the flash-window decode. This happens when reg_base places the block inside 0x4000–0x7FFF while fixed_flash_hi is set. The bench provokes it with base 0x12 (block at 0x4800). It expects both selects high inside the block and the emulation select low one byte past its end. Phase S0 closing is also combined with stretch and free-running clock in the same cycle. The result is judged against the open-phase decode.

// File: rtl/csdec_pkg.sv
`timescale 1ns/1ps
package csdec_pkg;

    typedef enum logic [1:0] {
        PH_S0 = 2'd0,
        PH_S1 = 2'd1,
        PH_S2 = 2'd2,
        PH_S3 = 2'd3
    } bus_phase_e;

    typedef enum logic [1:0] {
        RGN_NONE  = 2'd0,
        RGN_FLASH = 2'd1,
        RGN_EXT   = 2'd2
    } region_e;

    typedef struct packed {
        logic expanded;
        logic sel_en;
        logic flash_en;
        logic fixed_hi;
    } map_cfg_t;

    localparam int NUM_CS = 2;
    localparam int CS_EMU = 0;
    localparam int CS_EXT = 1;

    // A select may be low outside S0, or in S0 when stretched with a free-running clock.
    function automatic logic cs_window_open(bus_phase_e ph, logic stretch, logic eclk_free);
        return (ph != PH_S0) || (stretch && eclk_free);
    endfunction

    function automatic region_e region_for_channel(int ch);
        return (ch == CS_EMU) ? RGN_FLASH : RGN_EXT;
    endfunction

endpackage

// File: rtl/csdec_addr_decode.sv
`timescale 1ns/1ps
module csdec_addr_decode
    import csdec_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int REG_BASE_W = 5,
    parameter int REG_BLK_W  = 10
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [REG_BASE_W-1:0] reg_base,
    input  map_cfg_t              cfg,
    output region_e               region
);
    localparam int TAG_W = ADDR_W - REG_BLK_W;

    logic [TAG_W-1:0] base_tag;
    logic [1:0]       quadrant;
    logic             reg_hit;
    logic             flash_hit;

    assign base_tag = TAG_W'(reg_base);
    assign quadrant = addr[ADDR_W-1 -: 2];
    assign reg_hit  = (addr[ADDR_W-1 -: TAG_W] == base_tag);

    always_comb begin
        flash_hit = 1'b0;
        if (cfg.flash_en) begin
            flash_hit = quadrant[1] || ((quadrant == 2'b01) && cfg.fixed_hi);
        end
    end

    always_comb begin
        if (reg_hit)        region = RGN_NONE;
        else if (flash_hit) region = RGN_FLASH;
        else                region = RGN_EXT;
    end

endmodule

// File: rtl/csdec_timing.sv
`timescale 1ns/1ps
module csdec_timing
    import csdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  region_e           region,
    input  map_cfg_t          cfg,
    input  bus_phase_e        phase,
    input  logic              stretch,
    input  logic              eclk_free,
    input  logic              free_cycle,
    output logic [NUM_CS-1:0] cs_n,
    output logic              noacc
);
    logic live;

    assign live = cfg.expanded && cfg.sel_en && cs_window_open(phase, stretch, eclk_free);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_chan
        logic want;
        assign want = live && (region == region_for_channel(g));
        always_ff @(posedge clk) begin
            if (rst) cs_n[g] <= 1'b1;
            else     cs_n[g] <= ~want;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) noacc <= 1'b0;
        else     noacc <= free_cycle;
    end

    assert_mutex_R7: assert property (@(posedge clk) disable iff (rst)
        !(cs_n[CS_EMU] == 1'b0 && cs_n[CS_EXT] == 1'b0));

    assert_disabled_R2: assert property (@(posedge clk) disable iff (rst)
        (!cfg.sel_en || !cfg.expanded) |=> (cs_n == '1));

    assert_s0_gap_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_S0 && !(stretch && eclk_free)) |=> (cs_n == '1));

    assert_noacc_R9: assert property (@(posedge clk) disable iff (rst)
        free_cycle |=> noacc);

    assert_noacc_clear_R9: assert property (@(posedge clk) disable iff (rst)
        !free_cycle |=> !noacc);

    assert_reg_block_R6: assert property (@(posedge clk) disable iff (rst)
        (region == RGN_NONE) |=> (cs_n == '1));

endmodule

// File: rtl/chip_select_decoder.sv
`timescale 1ns/1ps
module chip_select_decoder
    import csdec_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int REG_BASE_W = 5,
    parameter int REG_BLK_W  = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  expanded,
    input  logic                  cs_enable,
    input  logic                  flash_enable,
    input  logic                  fixed_flash_hi,
    input  logic [REG_BASE_W-1:0] reg_base,
    input  logic [1:0]            bus_phase,
    input  logic                  stretched,
    input  logic                  eclk_free_run,
    input  logic                  free_cycle,
    output logic                  emu_cs_n,
    output logic                  ext_cs_n,
    output logic                  no_access
);
    map_cfg_t          cfg;
    region_e           region;
    logic [NUM_CS-1:0] cs_n;

    assign cfg = '{expanded: expanded, sel_en: cs_enable,
                   flash_en: flash_enable, fixed_hi: fixed_flash_hi};

    csdec_addr_decode #(
        .ADDR_W(ADDR_W), .REG_BASE_W(REG_BASE_W), .REG_BLK_W(REG_BLK_W)
    ) u_decode (
        .addr(bus_addr), .reg_base(reg_base), .cfg(cfg), .region(region)
    );

    csdec_timing u_timing (
        .clk(clk), .rst(rst), .region(region), .cfg(cfg),
        .phase(bus_phase_e'(bus_phase)), .stretch(stretched),
        .eclk_free(eclk_free_run), .free_cycle(free_cycle),
        .cs_n(cs_n), .noacc(no_access)
    );

    assign emu_cs_n = cs_n[CS_EMU];
    assign ext_cs_n = cs_n[CS_EXT];

endmodule

// File: tb/tb_chip_select_decoder.sv
`timescale 1ns/1ps
module tb_chip_select_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        expanded = 0, cs_enable = 0, flash_enable = 0, fixed_flash_hi = 0;
    logic [4:0]  reg_base = '0;
    logic [1:0]  bus_phase = '0;
    logic        stretched = 0, eclk_free_run = 0, free_cycle = 0;
    logic        emu_cs_n, ext_cs_n, no_access;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic  emu;
        logic  ext;
        logic  na;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    chip_select_decoder dut (.*);

    function automatic exp_t model(logic [15:0] a, logic ex, logic en, logic fe, logic fh,
                                   logic [4:0] rb, logic [1:0] ph, logic st, logic fr,
                                   logic fc, string tag);
        exp_t e;
        logic in_reg, in_flash;
        e.emu = 1; e.ext = 1; e.na = fc; e.tag = tag;
        in_reg   = (a[15:10] == {1'b0, rb});
        in_flash = fe && (a >= 16'h8000 || (a >= 16'h4000 && fh));
        if (ex && en && (ph != 0 || (st && fr)) && !in_reg) begin
            if (in_flash) e.emu = 0;
            else          e.ext = 0;
        end
        return e;
    endfunction

    task automatic drive(logic [15:0] a, logic ex, logic en, logic fe, logic fh,
                         logic [4:0] rb, logic [1:0] ph, logic st, logic fr,
                         logic fc, string tag);
        @(negedge clk);
        bus_addr = a; expanded = ex; cs_enable = en; flash_enable = fe;
        fixed_flash_hi = fh; reg_base = rb; bus_phase = ph; stretched = st;
        eclk_free_run = fr; free_cycle = fc;
        sb.push_back(model(a, ex, en, fe, fh, rb, ph, st, fr, fc, tag));
    endtask

    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (emu_cs_n !== e.emu || ext_cs_n !== e.ext || no_access !== e.na) begin
                errors++;
                $display("FAIL %s: got emu=%b ext=%b na=%b expected emu=%b ext=%b na=%b",
                         e.tag, emu_cs_n, ext_cs_n, no_access, e.emu, e.ext, e.na);
            end
            checks++;
            if (emu_cs_n === 1'b0 && ext_cs_n === 1'b0) begin
                errors++;
                $display("FAIL R7: got emu=0 ext=0 expected at most one low");
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (emu_cs_n !== 1 || ext_cs_n !== 1 || no_access !== 0) begin
            errors++;
            $display("FAIL R1: got emu=%b ext=%b na=%b expected 1 1 0",
                     emu_cs_n, ext_cs_n, no_access);
        end
        @(negedge clk);
        expanded = 1; cs_enable = 1; flash_enable = 1; bus_addr = 16'h9000; bus_phase = 1;
        @(negedge clk);
        checks++;
        if (emu_cs_n !== 1 || ext_cs_n !== 1) begin
            errors++;
            $display("FAIL R1: got emu=%b ext=%b expected 1 1 under reset", emu_cs_n, ext_cs_n);
        end
        rst = 0;

        // R3 flash windows
        drive(16'h9123, 1, 1, 1, 1, 5'h00, 1, 0, 0, 0, "R3 paged window");
        drive(16'hC000, 1, 1, 1, 1, 5'h00, 3, 0, 0, 0, "R3 upper fixed window");
        drive(16'hFFFF, 1, 1, 1, 0, 5'h00, 2, 0, 0, 0, "R3 top address");
        // R4 placement bit
        drive(16'h5000, 1, 1, 1, 1, 5'h00, 2, 0, 0, 0, "R4 low window flash");
        drive(16'h5000, 1, 1, 1, 0, 5'h00, 2, 0, 0, 0, "R4 low window external");
        drive(16'h4000, 1, 1, 1, 1, 5'h00, 1, 0, 0, 0, "R4 window start");
        drive(16'h3FFF, 1, 1, 1, 1, 5'h00, 1, 0, 0, 0, "R4 below window");
        // R5 flash disabled
        drive(16'h9000, 1, 1, 0, 1, 5'h00, 1, 0, 0, 0, "R5 flash off");
        drive(16'hC100, 1, 1, 0, 1, 5'h00, 3, 0, 0, 0, "R5 flash off upper");
        // R6 register block incl. removed ports and holes, priority over flash
        drive(16'h0002, 1, 1, 1, 1, 5'h00, 1, 0, 0, 0, "R6 removed port reg");
        drive(16'h03F0, 1, 1, 1, 1, 5'h00, 1, 0, 0, 0, "R6 hole");
        drive(16'h4810, 1, 1, 1, 1, 5'h12, 2, 0, 0, 0, "R6 block over flash");
        drive(16'h4BFF, 1, 1, 1, 1, 5'h12, 2, 0, 0, 0, "R6 block last byte");
        drive(16'h4C00, 1, 1, 1, 1, 5'h12, 2, 0, 0, 0, "R6 past block");
        drive(16'h0000, 1, 1, 1, 1, 5'h12, 2, 0, 0, 0, "R10 old base now external");
        drive(16'h2000, 1, 1, 1, 1, 5'h00, 3, 0, 0, 0, "R10 low external");
        // R2 disabled
        drive(16'h9000, 1, 0, 1, 1, 5'h00, 1, 0, 0, 0, "R2 select off");
        drive(16'h2000, 0, 1, 1, 1, 5'h00, 1, 0, 0, 0, "R2 single chip");
        // R8 phase gating
        drive(16'h9000, 1, 1, 1, 1, 5'h00, 0, 0, 0, 0, "R8 S0 gap");
        drive(16'h2000, 1, 1, 1, 1, 5'h00, 0, 1, 1, 0, "R8 stretched free clock");
        drive(16'h9000, 1, 1, 1, 1, 5'h00, 0, 1, 0, 0, "R8 stretched no free clock");
        drive(16'h9000, 1, 1, 1, 1, 5'h00, 0, 0, 1, 0, "R8 free clock no stretch");
        // R9 no-access
        drive(16'h9000, 1, 1, 1, 1, 5'h00, 2, 0, 0, 1, "R9 free cycle");
        drive(16'h9000, 1, 1, 1, 1, 5'h00, 3, 0, 0, 0, "R9 clear");
        drive(16'h1000, 0, 0, 0, 0, 5'h00, 0, 0, 0, 1, "R9 free cycle idle");
        // R7 sweep
        for (int i = 0; i < 64; i++) begin
            drive(16'(i * 16'h0400 + 16'h0011), 1, 1, i[0], i[1], 5'(i % 19),
                  2'(i % 4), i[2], i[3], i[4], "R7 sweep");
        end
        repeat (4) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule